// File: doc/BRIEF.md
# Quadrature Encoder Timer Counter

This block follows an incremental rotary or linear encoder that drives two phase inputs, A and B. A 16-bit counter moves up or down as those inputs change. Software picks one of four counting modes through a small synchronous register bus. Three of the modes decode the encoder: A counts while B sets the direction, B counts while A sets the direction, or both inputs are decoded as a full quadrature pair. The fourth mode is a free-running tick mode, with the direction set by software. Both phase inputs pass through a two-flop synchroniser and an edge detector before any decoding.

The counter runs between zero and a programmable limit. Counting up, it climbs from zero to the limit and then returns to zero. Counting down, it falls from the limit to zero and then reloads the limit. Each wrap produces a single-cycle update pulse. The limit register can be shadowed. When preload is on, a newly written limit takes effect only at the next wrap, so a cycle that is in progress always completes with the limit it started with. Any write to the limit register turns preload on.

Top module: `qenc_timer`

## Requirements
- R1: After the active-low synchronous reset, every register reads zero and `updEvent` is low.
- R2: The register offsets are: control at 0x00, mode at 0x08, counter at 0x24 and limit at 0x2C. The control register holds enable in bit 0, direction in bit 4 (1 = down) and preload in bit 7. The mode register holds the mode in bits [2:0]. Read data is combinational on `busAddr`. Any other offset reads zero, and writes to it have no effect.
- R3: In mode 1, each edge of A moves the count by one. The count goes up when the new level of A differs from B and down otherwise. Edges of B are ignored.
- R4: In mode 2, each edge of B moves the count by one. The count goes up when the new level of B equals A and down otherwise. Edges of A are ignored.
- R5: In mode 3, an edge on either input is counted using the R3 rule for A and the R4 rule for B. When A and B change in the same cycle, the count does not change.
- R6: In mode 0 and in modes 4 to 7, the counter steps once per clock while enabled, in the direction given by control bit 4.
- R7: While the enable bit is 0, the counter holds its value and no update pulse occurs.
- R8: A step up taken while the counter equals the limit sets the counter to 0 and raises `updEvent` for one cycle.
- R9: A step down taken while the counter is 0 loads the limit register into the counter and raises `updEvent` for one cycle.
- R10: A software write to the counter sets it to the written value, and this write wins over a step in the same cycle.
- R11: Writing the limit register also sets control bit 7. While bit 7 is 1, the active limit changes only at a wrap. While bit 7 is 0, the limit register is used directly.
- R12: In modes 1 to 3, the direction bit shows the direction of the last counted edge, and software writes to it are ignored. In the other modes, software writes the direction bit.
- R13: A change on an encoder input moves the counter at the third rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| encA | input | 1 | Encoder phase A, asynchronous |
| encB | input | 1 | Encoder phase B, asynchronous |
| busAddr | input | 8 | Register byte offset |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data for `busAddr` |
| updEvent | output | 1 | One-cycle pulse on each counter wrap |

## Verification
The assertions check on every cycle:
- both wrap rules, including the reload value and the update pulse;
- that the counter holds when there is neither a step nor a load;
- that a load wins over a step;
- that the shadow limit stays stable between wraps;
- that a simultaneous change of A and B is never counted;
- that the direction bit does not change between counted edges in the encoder modes.

Only the bench scenarios can show the following:
- the decoded direction across whole encoder sequences in each mode;
- the three-edge input latency;
- that a new limit becomes active one wrap later;
- that an unmapped offset is inert.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  parameter int DATA_W = 16;
  parameter int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_MODE   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_CNT    = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_PRESET = 8'h2C;

  localparam int CTRL_EN_BIT      = 0;
  localparam int CTRL_DIR_BIT     = 4;
  localparam int CTRL_PRELOAD_BIT = 7;
  localparam int MODE_W           = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_FREE  = 3'd0,
    MODE_CNT_A = 3'd1,
    MODE_CNT_B = 3'd2,
    MODE_QUAD  = 3'd3
  } qencMode_e;

  typedef struct packed {
    logic              step;
    logic              down;
    logic              cntLoad;
    logic              presetLoad;
    logic              preloadOn;
    logic [DATA_W-1:0] wrData;
  } qencStrobe_t;
endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic level,
  output logic edgeSeen
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[STAGES-1:0], din};
  end

  assign level    = pipe[STAGES-1];
  assign edgeSeen = pipe[STAGES-1] ^ pipe[STAGES];
endmodule

// File: rtl/qenc_ctrl.sv
module qenc_ctrl
  import qenc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              aLvl,
  input  logic              aEdge,
  input  logic              bLvl,
  input  logic              bEdge,
  input  logic [DATA_W-1:0] cntVal,
  input  logic [DATA_W-1:0] presetVal,
  output logic [DATA_W-1:0] busRdData,
  output qencStrobe_t       strb
);
  logic              enQ, dirQ, arpeQ;
  logic [MODE_W-1:0] modeQ;
  logic wrCtrl, wrMode, wrCnt, wrPreset;
  logic isEnc, encStep, encUp, aUp, bUp;

  assign wrCtrl   = busWrEn && (busAddr == OFS_CTRL);
  assign wrMode   = busWrEn && (busAddr == OFS_MODE);
  assign wrCnt    = busWrEn && (busAddr == OFS_CNT);
  assign wrPreset = busWrEn && (busAddr == OFS_PRESET);

  // phase decode: A edge counts up when new A differs from B,
  // B edge counts up when new B equals A
  assign aUp = aLvl ^ bLvl;
  assign bUp = ~(aLvl ^ bLvl);

  always_comb begin
    isEnc   = 1'b1;
    encStep = 1'b0;
    encUp   = 1'b1;
    case (modeQ)
      MODE_CNT_A: begin encStep = aEdge; encUp = aUp; end
      MODE_CNT_B: begin encStep = bEdge; encUp = bUp; end
      MODE_QUAD: begin
        encStep = aEdge ^ bEdge;
        encUp   = aEdge ? aUp : bUp;
      end
      default: isEnc = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ   <= 1'b0;
      dirQ  <= 1'b0;
      arpeQ <= 1'b0;
      modeQ <= '0;
    end else begin
      if (wrCtrl) begin
        enQ   <= busWrData[CTRL_EN_BIT];
        arpeQ <= busWrData[CTRL_PRELOAD_BIT];
      end else if (wrPreset) begin
        arpeQ <= 1'b1;
      end
      if (wrMode) modeQ <= busWrData[MODE_W-1:0];
      if (isEnc) begin
        if (enQ && encStep) dirQ <= ~encUp;
      end else if (wrCtrl) begin
        dirQ <= busWrData[CTRL_DIR_BIT];
      end
    end
  end

  always_comb begin
    strb.step       = enQ && (isEnc ? encStep : 1'b1);
    strb.down       = isEnc ? ~encUp : dirQ;
    strb.cntLoad    = wrCnt;
    strb.presetLoad = wrPreset;
    strb.preloadOn  = arpeQ;
    strb.wrData     = busWrData;
  end

  always_comb begin
    busRdData = '0;
    case (busAddr)
      OFS_CTRL: begin
        busRdData[CTRL_EN_BIT]      = enQ;
        busRdData[CTRL_DIR_BIT]     = dirQ;
        busRdData[CTRL_PRELOAD_BIT] = arpeQ;
      end
      OFS_MODE:   busRdData[MODE_W-1:0] = modeQ;
      OFS_CNT:    busRdData = cntVal;
      OFS_PRESET: busRdData = presetVal;
      default:    busRdData = '0;
    endcase
  end

  AST_DIR_HW_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (isEnc && !(enQ && encStep)) |=> $stable(dirQ)); // R12
  AST_QUAD_SIMUL: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_QUAD && aEdge && bEdge) |-> !strb.step); // R5
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !enQ |-> !strb.step); // R7
  AST_PRESET_ARMS: assert property (@(posedge clk) disable iff (!rstN)
    wrPreset |=> arpeQ); // R11
endmodule

// File: rtl/qenc_datapath.sv
module qenc_datapath
  import qenc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  qencStrobe_t       strb,
  output logic [DATA_W-1:0] cntVal,
  output logic [DATA_W-1:0] presetVal,
  output logic              updEvent
);
  logic [DATA_W-1:0] cntQ, presetQ, activeLimQ, effLimit;
  logic              evQ, wrapNow;

  assign effLimit = strb.preloadOn ? activeLimQ : presetQ;
  assign wrapNow  = strb.step && !strb.cntLoad &&
                    (strb.down ? (cntQ == '0) : (cntQ == effLimit));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ       <= '0;
      presetQ    <= '0;
      activeLimQ <= '0;
      evQ        <= 1'b0;
    end else begin
      if (strb.cntLoad)         cntQ <= strb.wrData;
      else if (wrapNow)         cntQ <= strb.down ? presetQ : '0;
      else if (strb.step)       cntQ <= strb.down ? cntQ - DATA_W'(1) : cntQ + DATA_W'(1);
      if (strb.presetLoad)      presetQ <= strb.wrData;
      if (!strb.preloadOn || wrapNow) activeLimQ <= presetQ;
      evQ <= wrapNow;
    end
  end

  assign cntVal    = cntQ;
  assign presetVal = presetQ;
  assign updEvent  = evQ;

  AST_WRAP_UP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.down && !strb.cntLoad && cntQ == effLimit)
      |=> (cntQ == '0 && updEvent)); // R8
  AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && strb.down && !strb.cntLoad && cntQ == '0)
      |=> (cntQ == $past(presetQ) && updEvent)); // R9
  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.step && !strb.cntLoad) |=> ($stable(cntQ) && !updEvent)); // R7
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntLoad |=> (cntQ == $past(strb.wrData) && !updEvent)); // R10
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.preloadOn && !wrapNow) |=> $stable(activeLimQ)); // R11
endmodule

// File: rtl/qenc_timer.sv
module qenc_timer
  import qenc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              encA,
  input  logic              encB,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              updEvent
);
  localparam int N_PHASE = 2;

  logic [N_PHASE-1:0] phRaw, phLvl, phEdge;
  logic [DATA_W-1:0]  cntVal, presetVal;
  qencStrobe_t        strb;

  assign phRaw = {encB, encA};

  for (genvar i = 0; i < N_PHASE; i++) begin : g_sync
    qenc_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rstN(rstN), .din(phRaw[i]),
      .level(phLvl[i]), .edgeSeen(phEdge[i])
    );
  end

  qenc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .aLvl(phLvl[0]), .aEdge(phEdge[0]), .bLvl(phLvl[1]), .bEdge(phEdge[1]),
    .cntVal(cntVal), .presetVal(presetVal),
    .busRdData(busRdData), .strb(strb)
  );

  qenc_datapath dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cntVal(cntVal), .presetVal(presetVal), .updEvent(updEvent)
  );
endmodule

// File: tb/qenc_timer_tb_top.sv
module qenc_timer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        encA = 1'b0, encB = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic        updEvent;
  int checks = 0, errors = 0, evCount = 0, ev0;
  logic [15:0] rd;

  always #4 clk = ~clk;

  qenc_timer dut_i (.*);

  always @(negedge clk) if (rstN && updEvent) evCount++;

  // fields {a, b, dir, count}: quadrature walk with limit 100
  localparam logic [18:0] QUAD_VEC [12] = '{
    {1'b1, 1'b0, 1'b0, 16'd1},   {1'b1, 1'b1, 1'b0, 16'd2},
    {1'b0, 1'b1, 1'b0, 16'd3},   {1'b0, 1'b0, 1'b0, 16'd4},
    {1'b0, 1'b1, 1'b1, 16'd3},   {1'b1, 1'b1, 1'b1, 16'd2},
    {1'b1, 1'b0, 1'b1, 16'd1},   {1'b0, 1'b0, 1'b1, 16'd0},
    {1'b0, 1'b1, 1'b1, 16'd100}, {1'b1, 1'b0, 1'b1, 16'd100},
    {1'b1, 1'b1, 1'b0, 16'd0},   {1'b0, 1'b0, 1'b0, 16'd0}
  };

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk);
    #1 busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic setPins(input logic a, input logic b);
    @(negedge clk);
    encA = a; encB = b;
    repeat (4) @(posedge clk);
  endtask

  task automatic runSteps(input logic [15:0] ctrlOn, input logic [15:0] ctrlOff, input int n);
    busWrite(8'h00, ctrlOn);
    repeat (n - 1) @(posedge clk);
    busWrite(8'h00, ctrlOff);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    busRead(8'h00, rd); check("R1 ctrl", rd, 16'h0);
    busRead(8'h08, rd); check("R1 mode", rd, 16'h0);
    busRead(8'h24, rd); check("R1 cnt", rd, 16'h0);
    busRead(8'h2C, rd); check("R1 preset", rd, 16'h0);
    check("R1 event", {15'b0, updEvent}, 16'h0);

    // quadrature table, limit 100 used directly (preload cleared)
    busWrite(8'h2C, 16'd100);
    busWrite(8'h08, 16'd3);
    busRead(8'h08, rd); check("R2 mode readback", rd, 16'd3);
    busWrite(8'h00, 16'h0001);
    ev0 = evCount;
    foreach (QUAD_VEC[i]) begin
      setPins(QUAD_VEC[i][18], QUAD_VEC[i][17]);
      busRead(8'h24, rd); check($sformatf("R5 quad cnt step %0d", i), rd, QUAD_VEC[i][15:0]);
      busRead(8'h00, rd); check($sformatf("R12 quad dir step %0d", i), {15'b0, rd[4]}, {15'b0, QUAD_VEC[i][16]});
    end
    check("R8 R9 quad wrap events", 16'(evCount - ev0), 16'd2);

    // R7 disabled: edge ignored and not counted later
    busWrite(8'h00, 16'h0000);
    setPins(1'b1, 1'b0);
    busRead(8'h24, rd); check("R7 disabled hold", rd, 16'd0);
    busWrite(8'h00, 16'h0001);
    repeat (4) @(posedge clk);
    busRead(8'h24, rd); check("R7 re-enable no count", rd, 16'd0);

    // R3 mode 1 with R13 latency, pins at (1,0)
    busWrite(8'h08, 16'd1);
    busWrite(8'h24, 16'd10);
    @(negedge clk); encA = 1'b0;
    @(posedge clk); @(posedge clk);
    busRead(8'h24, rd); check("R13 not yet after two edges", rd, 16'd10);
    busRead(8'h24, rd); check("R13 count after third edge", rd, 16'd9);
    setPins(1'b0, 1'b1); busRead(8'h24, rd); check("R3 B edge ignored", rd, 16'd9);
    setPins(1'b1, 1'b1); busRead(8'h24, rd); check("R3 A down", rd, 16'd8);
    setPins(1'b0, 1'b1); busRead(8'h24, rd); check("R3 A up", rd, 16'd9);
    busWrite(8'h00, 16'h0011);
    busRead(8'h00, rd); check("R12 dir write ignored in encoder mode", rd, 16'h0001);

    // R4 mode 2, pins at (0,1)
    busWrite(8'h08, 16'd2);
    setPins(1'b0, 1'b0); busRead(8'h24, rd); check("R4 B up", rd, 16'd10);
    setPins(1'b1, 1'b0); busRead(8'h24, rd); check("R4 A edge ignored", rd, 16'd10);
    setPins(1'b1, 1'b1); busRead(8'h24, rd); check("R4 B up again", rd, 16'd11);
    setPins(1'b1, 1'b0); busRead(8'h24, rd); check("R4 B down", rd, 16'd10);

    // R6 free mode counting down, R9 wrap
    busWrite(8'h00, 16'h0000);
    busWrite(8'h08, 16'd0);
    busWrite(8'h00, 16'h0010);
    busRead(8'h00, rd); check("R12 dir writable in free mode", rd, 16'h0010);
    busWrite(8'h24, 16'd3);
    ev0 = evCount;
    runSteps(16'h0011, 16'h0010, 4);
    busRead(8'h24, rd); check("R9 down wrap reloads limit", rd, 16'd100);
    check("R9 down wrap event", 16'(evCount - ev0), 16'd1);

    // R10 load wins over step
    busWrite(8'h00, 16'h0011);
    busWrite(8'h24, 16'd7);
    busWrite(8'h00, 16'h0010);
    busRead(8'h24, rd); check("R10 load then one step", rd, 16'd6);

    // R8 up wrap and R11 shadowed limit
    busWrite(8'h24, 16'd98);
    busWrite(8'h2C, 16'd20);
    busRead(8'h00, rd); check("R11 preset write sets preload", rd, 16'h0090);
    ev0 = evCount;
    runSteps(16'h0081, 16'h0080, 3);
    busRead(8'h24, rd); check("R8 up wrap at old limit", rd, 16'd0);
    check("R8 up wrap event", 16'(evCount - ev0), 16'd1);
    runSteps(16'h0081, 16'h0080, 21);
    busRead(8'h24, rd); check("R11 new limit active after wrap", rd, 16'd0);
    check("R11 second wrap event", 16'(evCount - ev0), 16'd2);

    // R11 preload off: limit register used directly
    busWrite(8'h2C, 16'd2);
    busWrite(8'h00, 16'h0000);
    busWrite(8'h24, 16'd0);
    runSteps(16'h0001, 16'h0000, 3);
    busRead(8'h24, rd); check("R11 direct limit wrap", rd, 16'd0);
    check("R6 free mode steps per clock", 16'(evCount - ev0), 16'd3);

    // R2 unmapped offset inert
    busWrite(8'h04, 16'hFFFF);
    busRead(8'h04, rd); check("R2 unmapped reads zero", rd, 16'h0);
    busRead(8'h00, rd); check("R2 ctrl untouched", rd, 16'h0000);
    busRead(8'h24, rd); check("R2 cnt untouched", rd, 16'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule